// File: doc/BRIEF.md
# Multi-Mode 8x8 Multiplier Unit

This unit multiplies two 8-bit register operands for a small RISC core's execute stage. A 3-bit mode chooses whether each operand is read as signed or unsigned, and whether the result is fractional. A fractional result is the full 16-bit product moved left by one place. The core presents both operands and the mode together with a one-cycle `start`. The unit then returns the 16-bit result as a low byte and a high byte, along with zero and carry flags, and raises `done` for exactly one cycle.

The surrounding core reads the operands from its register file. It always writes `res_lo` into register 0 and `res_hi` into register 1, whichever registers supplied the operands. It passes only the zero and carry flags on to its status register and leaves every other status bit alone. The latency is fixed at two clock edges, so the core can stall for a known number of cycles.

Top module: `mult8_multimode`

## Requirements
- R1: Mode encoding: `mode[2]` selects the fractional form. `mode[1:0]` selects signedness: 00 is unsigned×unsigned, 01 is signed×signed, 10 is signed first operand × unsigned second operand, and 11 behaves as unsigned×unsigned.
- R2: In a non-fractional mode, {`res_hi`,`res_lo`} is the low 16 bits of the two's-complement product of the operands as interpreted by the mode.
- R3: In a fractional mode, the result is the R2 product shifted left by one bit, with a zero entering bit 0. There is no saturation, so signed 0x80×0x80 gives 0x8000.
- R4: `flag_c` equals bit 15 of the product before any fractional shift.
- R5: `flag_z` is 1 exactly when the final 16-bit result is zero.
- R6: A `start` sampled while idle is accepted. `busy` is high for the next cycle. `done`, the result and the flags appear after the second clock edge counted from the one that sampled `start`.
- R7: `done` is high for exactly one cycle per accepted operation.
- R8: A `start` sampled while `busy` is high is ignored. It does not change the pending result and does not launch a second operation.
- R9: The result and the flags hold their values until the next accepted operation completes.
- R10: After reset, `res_lo`, `res_hi`, `flag_z`, `flag_c`, `busy` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, sampled on the rising edge |
| mode | input | 3 | Operation select (R1) |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| res_lo | output | 8 | Result bits 7:0 (for register 0) |
| res_hi | output | 8 | Result bits 15:8 (for register 1) |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Result valid pulse |

## Verification
The assertions assume that `start` is a single-cycle request from the core. They also assume that `mode`, `opa` and `opb` are valid in the cycle `start` is sampled and need not be held after that. The bench drives `start` for one cycle per operation and changes operands only on falling edges. It deliberately raises `start` during the busy cycle, with different operands, to exercise the rule that such a request is dropped. Apart from that single case, it waits for `done` before issuing the next operation.

// File: rtl/mult8_pkg.sv
package mult8_pkg;
  localparam int unsigned OP_W   = 8;
  localparam int unsigned PR_W   = 2 * OP_W;
  localparam int unsigned MODE_W = 3;

  // mode[1:0] signedness field
  localparam logic [1:0] SG_UU = 2'b00;
  localparam logic [1:0] SG_SS = 2'b01;
  localparam logic [1:0] SG_SU = 2'b10;

  function automatic logic first_is_signed(input logic [1:0] sg);
    return (sg == SG_SS) || (sg == SG_SU);
  endfunction

  function automatic logic second_is_signed(input logic [1:0] sg);
    return (sg == SG_SS);
  endfunction

  // Widen an operand by one bit, sign or zero filling
  function automatic logic signed [OP_W:0] widen(input logic [OP_W-1:0] v,
                                                 input logic is_signed);
    return {is_signed & v[OP_W-1], v};
  endfunction

  // Product modulo 2^PR_W of two widened operands
  function automatic logic [PR_W-1:0] raw_product(input logic signed [OP_W:0] a,
                                                  input logic signed [OP_W:0] b);
    logic signed [PR_W-1:0] pa;
    logic signed [PR_W-1:0] pb;
    pa = PR_W'(a);
    pb = PR_W'(b);
    return $unsigned(pa * pb);
  endfunction

  function automatic logic [PR_W-1:0] frac_adjust(input logic [PR_W-1:0] p,
                                                  input logic frac);
    return frac ? {p[PR_W-2:0], 1'b0} : p;
  endfunction
endpackage

// File: rtl/mult8_ctrl.sv
module mult8_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic done
);
  logic busy_q;
  logic done_q;

  assign accept = start & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= accept;
      done_q <= busy_q;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/mult8_opnd.sv
module mult8_opnd
  import mult8_pkg::*;
#(
  parameter int unsigned W  = OP_W,
  parameter int unsigned MW = MODE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MW-1:0]       mode,
  input  logic [W-1:0]        opa,
  input  logic [W-1:0]        opb,
  output logic signed [W:0]   a_wide,
  output logic signed [W:0]   b_wide,
  output logic                frac
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_wide <= '0;
      b_wide <= '0;
      frac   <= 1'b0;
    end else if (load) begin
      a_wide <= widen(opa, first_is_signed(mode[1:0]));
      b_wide <= widen(opb, second_is_signed(mode[1:0]));
      frac   <= mode[MW-1];
    end
  end
endmodule

// File: rtl/mult8_core.sv
module mult8_core
  import mult8_pkg::*;
#(
  parameter int unsigned W = OP_W,
  localparam int unsigned PW = 2 * W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic signed [W:0] a_wide,
  input  logic signed [W:0] b_wide,
  input  logic              frac,
  output logic [PW-1:0]     result,
  output logic              z,
  output logic              c
);
  logic [PW-1:0] prod;
  logic [PW-1:0] final_v;

  assign prod    = raw_product(a_wide, b_wide);
  assign final_v = frac_adjust(prod, frac);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      z      <= 1'b0;
      c      <= 1'b0;
    end else if (fire) begin
      result <= final_v;
      z      <= (final_v == '0);
      c      <= prod[PW-1];
    end
  end
endmodule

// File: rtl/mult8_multimode.sv
module mult8_multimode
  import mult8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [OP_W-1:0]   opa,
  input  logic [OP_W-1:0]   opb,
  output logic [OP_W-1:0]   res_lo,
  output logic [OP_W-1:0]   res_hi,
  output logic              flag_z,
  output logic              flag_c,
  output logic              busy,
  output logic              done
);
  logic                   accept;
  logic signed [OP_W:0]   a_wide;
  logic signed [OP_W:0]   b_wide;
  logic                   frac_q;
  logic [PR_W-1:0]        result;

  mult8_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .accept(accept), .busy(busy), .done(done)
  );

  mult8_opnd #(.W(OP_W), .MW(MODE_W)) u_opnd (
    .clk(clk), .rst_n(rst_n), .load(accept), .mode(mode),
    .opa(opa), .opb(opb), .a_wide(a_wide), .b_wide(b_wide), .frac(frac_q)
  );

  mult8_core #(.W(OP_W)) u_core (
    .clk(clk), .rst_n(rst_n), .fire(busy),
    .a_wide(a_wide), .b_wide(b_wide), .frac(frac_q),
    .result(result), .z(flag_z), .c(flag_c)
  );

  assign res_lo = result[OP_W-1:0];
  assign res_hi = result[PR_W-1:OP_W];
endmodule

// File: rtl/mult8_checker.sv
module mult8_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [7:0] res_lo,
  input logic [7:0] res_hi,
  input logic       flag_z,
  input logic       flag_c,
  input logic       frac_q
);
  a_r6_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r6_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  a_r9_hold_res: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(res_lo) && $stable(res_hi) && $stable(flag_z) && $stable(flag_c)));
  a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_z == ({res_hi, res_lo} == 16'h0000)));
  a_r3_frac_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (done && frac_q) |-> (res_lo[0] == 1'b0));
  a_r4_carry_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !frac_q) |-> (flag_c == res_hi[7]));
endmodule

bind mult8_multimode mult8_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .res_lo(res_lo), .res_hi(res_hi), .flag_z(flag_z), .flag_c(flag_c),
  .frac_q(frac_q)
);

// File: tb/sim_mult8_multimode.sv
`timescale 1ns/1ps
module sim_mult8_multimode;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [7:0] opa = 8'd0;
  logic [7:0] opb = 8'd0;
  logic [7:0] res_lo, res_hi;
  logic       flag_z, flag_c, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mult8_multimode u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .opa(opa), .opb(opb),
    .res_lo(res_lo), .res_hi(res_hi), .flag_z(flag_z), .flag_c(flag_c),
    .busy(busy), .done(done)
  );

  // {mode, a, b, expected result, z, c}
  localparam int NV = 16;
  localparam logic [36:0] VEC [NV] = '{
    {3'd0, 8'h0C, 8'h0A, 16'h0078, 1'b0, 1'b0},  // R2 unsigned
    {3'd0, 8'hFF, 8'hFF, 16'hFE01, 1'b0, 1'b1},  // R2 R4
    {3'd0, 8'h00, 8'h55, 16'h0000, 1'b1, 1'b0},  // R5
    {3'd1, 8'hFF, 8'hFF, 16'h0001, 1'b0, 1'b0},  // R2 signed
    {3'd1, 8'h80, 8'h7F, 16'hC080, 1'b0, 1'b1},  // R2 R4
    {3'd2, 8'hFF, 8'hFF, 16'hFF01, 1'b0, 1'b1},  // R1 mixed
    {3'd2, 8'h7F, 8'h80, 16'h3F80, 1'b0, 1'b0},  // R1 second unsigned
    {3'd3, 8'hFF, 8'hFF, 16'hFE01, 1'b0, 1'b1},  // R1 field 11
    {3'd4, 8'hFF, 8'hFF, 16'hFC02, 1'b0, 1'b1},  // R3 R4
    {3'd4, 8'h40, 8'h40, 16'h2000, 1'b0, 1'b0},  // R3
    {3'd5, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},  // R3 no saturation
    {3'd5, 8'hC0, 8'h40, 16'hE000, 1'b0, 1'b1},  // R3 R4
    {3'd5, 8'h80, 8'h7F, 16'h8100, 1'b0, 1'b1},  // R3 R4
    {3'd6, 8'h80, 8'hFF, 16'h0100, 1'b0, 1'b1},  // R3 R4 mixed
    {3'd6, 8'h00, 8'h12, 16'h0000, 1'b1, 1'b0},  // R5 frac
    {3'd7, 8'h40, 8'h40, 16'h2000, 1'b0, 1'b0}   // R1 field 11 frac
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    mode = m; opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {res_hi, res_lo, 6'd0, flag_z, flag_c, busy, done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      launch(VEC[i][36:34], VEC[i][33:26], VEC[i][25:18]);
      check("R6 busy", {31'd0, busy}, 32'd1);
      check("R6 no early done", {31'd0, done}, 32'd0);
      @(negedge clk);
      check("R6 done", {31'd0, done}, 32'd1);
      check("R2 R3 result", {16'd0, res_hi, res_lo}, {16'd0, VEC[i][17:2]});
      check("R5 zero", {31'd0, flag_z}, {31'd0, VEC[i][1]});
      check("R4 carry", {31'd0, flag_c}, {31'd0, VEC[i][0]});
      @(negedge clk);
      check("R7 done low", {31'd0, done}, 32'd0);
      check("R9 hold", {15'd0, flag_z, res_hi, res_lo}, {15'd0, VEC[i][1], VEC[i][17:2]});
    end

    // R8 start during busy is ignored
    launch(3'd0, 8'h03, 8'h05);
    mode = 3'd0; opa = 8'hFF; opb = 8'hFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 result", {16'd0, res_hi, res_lo}, 32'h0000000F);
    check("R8 no relaunch", {30'd0, busy, done}, 32'd1);
    @(negedge clk);
    check("R8 idle", {30'd0, busy, done}, 32'd0);
    check("R8 kept", {16'd0, res_hi, res_lo}, 32'h0000000F);

    // R9 hold over idle cycles with changing inputs
    opa = 8'h77; opb = 8'h11; mode = 3'd5;
    repeat (4) @(negedge clk);
    check("R9 idle hold", {16'd0, res_hi, res_lo}, 32'h0000000F);

    // R10 reset mid-result
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset", {res_hi, res_lo, 6'd0, flag_z, flag_c, busy, done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule